// File: doc/BRIEF.md
# Logarithmic running max/min filter

This block is a streaming one-dimensional rank filter. Each accepted input sample produces one result: the largest, or the smallest, of the most recent `N` accepted samples. The window length `N` is a power of two. The result is useful for grey-scale dilation (max) and erosion (min) on a sample stream. To filter an image, apply the block once along rows and once along columns.

The datapath does not compare the whole window at once. It is a chain of `K = log2(N)` stages built by recursive doubling. Stage `j` (counting from 1) holds a delay line of `2^(j-1)` samples. Each stage combines its current input with the copy of its input taken `2^(j-1)` accepted samples earlier, through one two-input compare-select, followed by one pipeline register. This costs `K` compare-selects and `N-1` delay registers for each result. A small state machine gates the output strobe during warm-up. It has two states: `FILL` counts results leaving the last stage, and `RUN` passes every result through. Its transitions are `FILL_STEP` (`FILL` to `FILL`, a result arrives and the count is below `N-1`), `WINDOW_FULL` (`FILL` to `RUN`, the `N`-th result arrives), `RUN_HOLD` (`RUN` to `RUN`) and `RESTART` (any state to `FILL` on reset).

The operator is chosen by a static mode input that is changed only while reset is applied. A build parameter selects how the minimum is formed. The plain form uses a direct less-or-equal select. The other form complements both operands and the result against the all-ones word, so that the max comparator serves both operators.

Top module: `rmm_filter`

## Requirements
- R1: With `mode` = 0 (max), every `out_data` strobed by `out_valid` equals the unsigned maximum of the last `N` samples accepted on `in_valid`, ending with the sample this result belongs to.
- R2: With `mode` = 1 (min), every strobed `out_data` equals the unsigned minimum of the same `N` samples.
- R3: A sample accepted at the rising edge that ends cycle c has its result visible with `out_valid` high during cycle c+`K`, where `K` = log2(`N`). Each accepted sample yields at most one result.
- R4: After reset, `out_valid` stays low for the results of the first `N-1` accepted samples. It is high for the result of the `N`-th accepted sample and of every sample after it.
- R5: Cycles with `in_valid` low do not advance any delay line, and they raise no `out_valid`. Results equal those of the same sample stream applied without gaps.
- R6: A synchronous active-high `rst` clears all delay and pipeline registers and the fill count. In the cycle after reset is released, `out_valid` is 0 and `out_data` is 0, and the warm-up of R4 starts again.
- R7: Stage `j` combines its input with that input delayed by `2^(j-1)` accepted samples. Each stage's registered result is not below (max) or not above (min) both of its operands.
- R8: With `MIN_VIA_BIAS` = 1, the minimum is computed as the complement of the maximum of the complemented operands. The results are identical to R2.
- R9: Equal samples are handled without error: a window of identical values yields that value in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | Operator: 0 = max, 1 = min; static outside reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | W | Unsigned input sample |
| out_valid | output | 1 | Result strobe, gated during warm-up |
| out_data | output | W | Filtered result |

## Verification
The bench builds two copies side by side from the same stimulus. The first uses the default 8-sample window of 8-bit samples with the direct minimum, giving three stages with delays 1, 2 and 4. The second uses a 4-sample window of 6-bit samples with the complement-based minimum. This lets the two minimum forms and two stage counts be checked against one reference model. The short window and narrow word make ties and saturation at the all-ones value frequent. They also make the warm-up boundary and the latency of both pipelines observable in short scenarios.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
    typedef enum logic { OP_MAX = 1'b0, OP_MIN = 1'b1 } rmm_op_e;
    typedef enum logic { ST_FILL = 1'b0, ST_RUN = 1'b1 } rmm_fill_e;
endpackage

// File: rtl/rmm_delay.sv
module rmm_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] tap
);
    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (en) begin
            regs[0] <= din;
            for (int i = 1; i < DEPTH; i++) regs[i] <= regs[i-1];
        end
    end

    assign tap = regs[DEPTH-1];
endmodule

// File: rtl/rmm_cmpsel.sv
module rmm_cmpsel
    import rmm_pkg::*;
#(
    parameter int W            = 8,
    parameter bit MIN_VIA_BIAS = 1'b0
) (
    input  rmm_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    generate
        if (MIN_VIA_BIAS) begin : g_bias
            logic [W-1:0] ca, cb, mx;
            always_comb begin
                ca = (op == OP_MIN) ? ~a : a;
                cb = (op == OP_MIN) ? ~b : b;
                mx = (ca >= cb) ? ca : cb;
                y  = (op == OP_MIN) ? ~mx : mx;
            end
        end else begin : g_direct
            always_comb begin
                if (op == OP_MIN) y = (a <= b) ? a : b;
                else              y = (a >= b) ? a : b;
            end
        end
    endgenerate
endmodule

// File: rtl/rmm_stage.sv
module rmm_stage
    import rmm_pkg::*;
#(
    parameter int W            = 8,
    parameter int DELAY        = 1,
    parameter bit MIN_VIA_BIAS = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  rmm_op_e      op,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic [W-1:0] tap, sel;

    rmm_delay #(.W(W), .DEPTH(DELAY)) u_dly (
        .clk(clk), .rst(rst), .en(in_v), .din(in_d), .tap(tap)
    );

    rmm_cmpsel #(.W(W), .MIN_VIA_BIAS(MIN_VIA_BIAS)) u_cs (
        .op(op), .a(in_d), .b(tap), .y(sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_d <= '0;
        end else begin
            out_v <= in_v;
            if (in_v) out_d <= sel;
        end
    end

    // R7 / R1: a max stage result is not below either operand
    a_r7_max_covers: assert property (@(posedge clk) disable iff (rst)
        (in_v && op == OP_MAX) |=> (out_d >= $past(in_d) && out_d >= $past(tap)));

    // R7 / R2: a min stage result is not above either operand
    a_r7_min_covers: assert property (@(posedge clk) disable iff (rst)
        (in_v && op == OP_MIN) |=> (out_d <= $past(in_d) && out_d <= $past(tap)));

    // R5: an idle cycle leaves the stage result untouched
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_v |=> ($stable(out_d) && !out_v));

    // R5: the delay tap moves only when a sample is accepted
    a_r5_tap_frozen: assert property (@(posedge clk) disable iff (rst)
        !in_v |=> $stable(tap));
endmodule

// File: rtl/rmm_fill_ctrl.sv
module rmm_fill_ctrl
    import rmm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic res_v,
    output logic out_valid
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    rmm_fill_e      state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_FILL: begin
                if (res_v) begin
                    if (cnt == LAST) state_nx = ST_RUN;
                    else             cnt_nx   = cnt + 1'b1;
                end
            end
            ST_RUN: state_nx = ST_RUN;
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FILL: out_valid = res_v && (cnt == LAST);
            ST_RUN:  out_valid = res_v;
            default: out_valid = 1'b0;
        endcase
    end

    // R4: once the window is full the gate stays open until reset
    a_r4_run_sticky: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN |=> state == ST_RUN);

    // R4: the fill count never passes the last warm-up position
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4: leaving FILL happens only on the result that completes the window
    a_r4_full_on_result: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && !res_v) |=> state == ST_FILL);
endmodule

// File: rtl/rmm_filter.sv
module rmm_filter
    import rmm_pkg::*;
#(
    parameter int W            = 8,
    parameter int N            = 8,
    parameter bit MIN_VIA_BIAS = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int K = $clog2(N);

    rmm_op_e      op;
    logic [W-1:0] sd [K+1];
    logic         sv [K+1];

    assign op    = rmm_op_e'(mode);
    assign sd[0] = in_data;
    assign sv[0] = in_valid;

    generate
        for (genvar j = 0; j < K; j++) begin : g_stage
            rmm_stage #(
                .W(W), .DELAY(1 << j), .MIN_VIA_BIAS(MIN_VIA_BIAS)
            ) u_stage (
                .clk(clk), .rst(rst), .op(op),
                .in_v(sv[j]), .in_d(sd[j]),
                .out_v(sv[j+1]), .out_d(sd[j+1])
            );
        end
    endgenerate

    rmm_fill_ctrl #(.N(N)) u_fill (
        .clk(clk), .rst(rst), .res_v(sv[K]), .out_valid(out_valid)
    );

    assign out_data = sd[K];

    // R3: a strobed result always comes from a result leaving the last stage
    a_r3_valid_from_pipe: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sv[K]);

    // R6: the cycle after reset shows an empty, silent pipeline
    a_r6_reset_clean: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));
endmodule

// File: tb/sim_rmm_filter.sv
module sim_rmm_filter;
    typedef struct { int due; int val; } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       vin = 1'b0;
    logic [7:0] din = '0;
    logic       ov0, ov1;
    logic [7:0] od0;
    logic [5:0] od1;

    int n_chk = 0, n_fail = 0, cyc = 0, vcnt0 = 0;
    int hist0[$], hist1[$];
    exp_t q0[$], q1[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rmm_filter #(.W(8), .N(8), .MIN_VIA_BIAS(1'b0)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(vin), .in_data(din),
        .out_valid(ov0), .out_data(od0));

    rmm_filter #(.W(6), .N(4), .MIN_VIA_BIAS(1'b1)) u1 (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(vin), .in_data(din[5:0]),
        .out_valid(ov1), .out_data(od1));

    function automatic int win_ref(input int h[$], input bit mn);
        int r = h[0];
        foreach (h[i]) r = mn ? ((h[i] < r) ? h[i] : r) : ((h[i] > r) ? h[i] : r);
        return r;
    endfunction

    function automatic string optag();
        return mode ? "R2" : "R1";
    endfunction

    // Scoreboard: results must appear exactly K cycles after acceptance (R3).
    always @(negedge clk) begin
        if (!rst) begin
            if (ov0) vcnt0++;
            if (q0.size() > 0 && q0[0].due == cyc) begin
                n_chk++;
                if (!ov0 || int'(od0) != q0[0].val) begin
                    n_fail++;
                    $display("FAIL %s/R3 u0 cyc %0d: valid=%0b data=%0d expected valid=1 data=%0d",
                             optag(), cyc, ov0, od0, q0[0].val);
                end
                void'(q0.pop_front());
            end else if (ov0) begin
                n_chk++; n_fail++;
                $display("FAIL R4 u0 cyc %0d: valid=1 data=%0d expected valid=0", cyc, od0);
            end
            if (q1.size() > 0 && q1[0].due == cyc) begin
                n_chk++;
                if (!ov1 || int'(od1) != q1[0].val) begin
                    n_fail++;
                    $display("FAIL R7/R8 u1 cyc %0d: valid=%0b data=%0d expected valid=1 data=%0d",
                             cyc, ov1, od1, q1[0].val);
                end
                void'(q1.pop_front());
            end else if (ov1) begin
                n_chk++; n_fail++;
                $display("FAIL R4 u1 cyc %0d: valid=1 data=%0d expected valid=0", cyc, od1);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int v);
        @(negedge clk);
        vin = 1'b1;
        din = 8'(v);
        hist0.push_back(v & 255);
        if (hist0.size() > 8) void'(hist0.pop_front());
        if (hist0.size() == 8) q0.push_back('{cyc + 3, win_ref(hist0, mode)});
        hist1.push_back(v & 63);
        if (hist1.size() > 4) void'(hist1.pop_front());
        if (hist1.size() == 4) q1.push_back('{cyc + 2, win_ref(hist1, mode)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vin = 1'b0;
        end
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        vin = 1'b0; rst = 1'b1; mode = m;
        hist0.delete(); hist1.delete(); q0.delete(); q1.delete();
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check(!ov0 && od0 == 0, "R6 u0 reset state (valid,data)", {ov0, od0}, 0);
        check(!ov1 && od1 == 0, "R6 u1 reset state (valid,data)", {ov1, od1}, 0);
    endtask

    task automatic drain();
        idle(6);
        check(q0.size() == 0, "R3 u0 results outstanding", q0.size(), 0);
        check(q1.size() == 0, "R3 u1 results outstanding", q1.size(), 0);
    endtask

    task automatic t_fill(input bit m);
        int base;
        do_reset(m);
        base = vcnt0;
        for (int i = 0; i < 7; i++) drive(10 + i * 3);
        idle(6);
        check(vcnt0 - base == 0, "R4 no result before window full", vcnt0 - base, 0);
        drive(200);
        idle(6);
        check(vcnt0 - base == 1, "R4 first result on N-th sample", vcnt0 - base, 1);
        drain();
    endtask

    task automatic t_random(input bit m, input int n);
        do_reset(m);
        for (int i = 0; i < n; i++) drive(int'($urandom_range(0, 255)));
        drain();
    endtask

    task automatic t_ramp(input bit m, input bit up);
        do_reset(m);
        for (int i = 0; i < 48; i++) drive(up ? i * 5 : 255 - i * 5);
        drain();
    endtask

    task automatic t_gaps(input bit m);
        do_reset(m);
        for (int i = 0; i < 80; i++) begin
            drive(int'($urandom_range(0, 255)));
            idle(int'($urandom_range(0, 3)));   // R5: gaps must not shift the window
        end
        drain();
    endtask

    task automatic t_ties(input bit m);
        do_reset(m);
        for (int i = 0; i < 12; i++) drive(63);   // R9: equal samples, all-ones in u1
        for (int i = 0; i < 12; i++) drive((i % 2) ? 7 : 7 + 64);
        drain();
    endtask

    task automatic t_midreset(input bit m);
        int base;
        do_reset(m);
        for (int i = 0; i < 20; i++) drive(int'($urandom_range(0, 255)));
        do_reset(m);                              // R6: restart of warm-up
        base = vcnt0;
        for (int i = 0; i < 5; i++) drive(99);
        idle(6);
        check(vcnt0 - base == 0, "R6 warm-up restarts after reset", vcnt0 - base, 0);
        for (int i = 0; i < 10; i++) drive(i * 20);
        drain();
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            t_fill(1'(m));
            t_random(1'(m), 300);
            t_ramp(1'(m), 1'b1);
            t_ramp(1'(m), 1'b0);
            t_gaps(1'(m));
            t_ties(1'(m));
            t_midreset(1'(m));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule